// File: doc/BRIEF.md
# Spare-Row Address Remapper

This block sits in front of a memory's physical row decoder. The array holds more physical rows than the capacity it advertises. The extra rows, placed directly above the visible range, serve as spares. A small repair table lists rows known to be defective. The table is written once, from a non-volatile repair source, after test at fabrication or boot.

On every access the logical row address is compared with every valid table entry in the same cycle. When it matches an entry, the physical row becomes the spare that belongs to that entry. When nothing matches, the address goes through unchanged. A defective row is therefore never selected, and software sees a defect-free memory of constant size.

A separate pulse input counts the defective rows found by test. If that count exceeds the number of spares, the part is flagged as unrepairable instead of being offered with a smaller capacity. A lock input seals the table and the count. After that, both stay fixed until reset.

Top module: `spare_row_remap`

## Requirements
- R1: The physical row address is wide enough for 2^ROW_W visible rows plus NUM_SPARES spares. Table entry k always maps to physical row 2^ROW_W + k, which is 64 + k with the default ROW_W = 6.
- R2: When no valid entry matches `log_row`, `phys_row` equals `log_row` zero-extended and `remap_hit` is 0.
- R3: When a valid entry k matches `log_row`, `phys_row` is 2^ROW_W + k and `remap_hit` is 1. The result is combinational and appears in the same cycle as the address.
- R4: An entry loaded with `load_valid` = 0 never matches, whatever address it holds.
- R5: When several valid entries hold the same address, the entry with the lowest index selects the spare.
- R6: A load (`load_en` high at a rising edge) writes entry `load_idx` only while `repair_lock` is low and the table has not been sealed. A load made while `repair_lock` is high has no effect. A write becomes visible in the cycle after the edge.
- R7: Once `repair_lock` is high at a rising edge, the table is sealed. Loads and fault reports are then ignored, even after `repair_lock` returns low, until reset.
- R8: `unrepairable` rises in the cycle after the (NUM_SPARES+1)-th accepted `fault_report` pulse and stays high until reset. It stays low after exactly NUM_SPARES pulses.
- R9: Synchronous active-high `rst` empties the table, clears the fault count and unseals the table, so every address passes through and `unrepairable` is 0.
- R10: Rewriting an entry replaces its address. The old address passes through again, or falls to another matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| log_row | input | ROW_W | Logical row address of the access |
| phys_row | output | PHYS_W | Row address sent to the physical decoder |
| remap_hit | output | 1 | High when the access was steered to a spare |
| load_en | input | 1 | Write strobe for a repair table entry |
| load_idx | input | IDX_W | Index of the entry to write |
| load_addr | input | ROW_W | Defective row address stored in the entry |
| load_valid | input | 1 | Valid bit stored in the entry |
| fault_report | input | 1 | One-cycle pulse per defective row found by test |
| repair_lock | input | 1 | Seals the table and the fault count |
| unrepairable | output | 1 | More defective rows were reported than spares exist |

## Verification
The bench loads duplicate addresses into two entries. A design that picked the highest index, or OR-ed the indices together, would steer the access to the wrong spare or to a nonexistent row. It also invalidates an entry that still holds a matching address and rewrites an entry. A design that ignored the valid bit, or kept stale matches, would keep steering rows that should pass through.

After the lock is raised and dropped again, the bench issues further loads and fault reports. A design that treated the lock as a level, and not as a sticky seal, would accept them. The fault count is taken to exactly the spare count and then one beyond, which exposes a comparison that is off by one in either direction.

// File: rtl/srr_pkg.sv
package srr_pkg;

    localparam int DEF_ROW_W  = 6;
    localparam int DEF_SPARES = 4;

    typedef enum logic {
        LOCK_OPEN   = 1'b0,
        LOCK_SEALED = 1'b1
    } lock_state_e;

    // rows visible plus spares stacked above them
    function automatic int phys_width(input int row_w, input int spares);
        return $clog2((1 << row_w) + spares);
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // enough to hold spares+1 (saturation point)
    function automatic int tally_width(input int spares);
        return $clog2(spares + 2);
    endfunction

endpackage

// File: rtl/remap_table.sv
module remap_table
    import srr_pkg::*;
#(
    parameter int ROW_W      = DEF_ROW_W,
    parameter int NUM_SPARES = DEF_SPARES,
    parameter int IDX_W      = idx_width(NUM_SPARES)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                load_en,
    input  logic [IDX_W-1:0]                    load_idx,
    input  logic [ROW_W-1:0]                    load_addr,
    input  logic                                load_valid,
    input  logic                                repair_lock,
    output logic [NUM_SPARES-1:0]               tbl_valid,
    output logic [NUM_SPARES-1:0][ROW_W-1:0]    tbl_addr,
    output logic                                sealed
);

    lock_state_e lock_q;
    logic        write_ok;

    assign sealed   = (lock_q == LOCK_SEALED);
    assign write_ok = load_en && !repair_lock && !sealed;

    always_ff @(posedge clk) begin
        if (rst)              lock_q <= LOCK_OPEN;
        else if (repair_lock) lock_q <= LOCK_SEALED;
    end

    for (genvar k = 0; k < NUM_SPARES; k++) begin : g_entry
        logic sel;
        assign sel = write_ok && (load_idx == IDX_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                tbl_valid[k] <= 1'b0;
                tbl_addr[k]  <= '0;
            end else if (sel) begin
                tbl_valid[k] <= load_valid;
                tbl_addr[k]  <= load_addr;
            end
        end
    end

    // R7: the seal holds until reset
    assert_seal_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        sealed |=> sealed);

    // R7: a sealed table never changes
    assert_sealed_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        sealed |=> ($stable(tbl_valid) && $stable(tbl_addr)));

    // R6: loads under an active lock leave the table alone
    assert_locked_load_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (load_en && repair_lock) |=> ($stable(tbl_valid) && $stable(tbl_addr)));

endmodule

// File: rtl/remap_match.sv
module remap_match
    import srr_pkg::*;
#(
    parameter int ROW_W      = DEF_ROW_W,
    parameter int NUM_SPARES = DEF_SPARES,
    parameter int IDX_W      = idx_width(NUM_SPARES)
) (
    input  logic [ROW_W-1:0]                    log_row,
    input  logic [NUM_SPARES-1:0]               tbl_valid,
    input  logic [NUM_SPARES-1:0][ROW_W-1:0]    tbl_addr,
    output logic                                hit,
    output logic [IDX_W-1:0]                    hit_idx
);

    logic [NUM_SPARES-1:0] eq;
    logic [NUM_SPARES-1:0] winner;

    for (genvar k = 0; k < NUM_SPARES; k++) begin : g_cmp
        assign eq[k] = tbl_valid[k] && (tbl_addr[k] == log_row);
    end

    // lowest index takes priority
    always_comb begin
        logic seen;
        seen    = 1'b0;
        winner  = '0;
        hit_idx = '0;
        for (int k = 0; k < NUM_SPARES; k++) begin
            winner[k] = eq[k] && !seen;
            seen      = seen | eq[k];
            hit_idx   = hit_idx | (IDX_W'(k) & {IDX_W{winner[k]}});
        end
    end

    assign hit = |eq;

endmodule

// File: rtl/fault_tally.sv
module fault_tally
    import srr_pkg::*;
#(
    parameter int NUM_SPARES = DEF_SPARES,
    parameter int CNT_W      = tally_width(NUM_SPARES)
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_report,
    input  logic repair_lock,
    input  logic sealed,
    output logic unrepairable
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NUM_SPARES);
    localparam logic [CNT_W-1:0] SAT   = CNT_W'(NUM_SPARES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             count_en;

    assign count_en = fault_report && !repair_lock && !sealed;

    always_ff @(posedge clk) begin
        if (rst)                           cnt_q <= '0;
        else if (count_en && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end

    assign unrepairable = (cnt_q > LIMIT);

    // R8: once flagged, stays flagged until reset
    assert_unrep_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        unrepairable |=> unrepairable);

    // R7: no growth of the count after sealing
    assert_sealed_tally_R7: assert property (@(posedge clk) disable iff (rst)
        sealed |=> $stable(cnt_q));

endmodule

// File: rtl/spare_row_remap.sv
module spare_row_remap
    import srr_pkg::*;
#(
    parameter int ROW_W      = DEF_ROW_W,
    parameter int NUM_SPARES = DEF_SPARES,
    parameter int PHYS_W     = phys_width(ROW_W, NUM_SPARES),
    parameter int IDX_W      = idx_width(NUM_SPARES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ROW_W-1:0]  log_row,
    output logic [PHYS_W-1:0] phys_row,
    output logic              remap_hit,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [ROW_W-1:0]  load_addr,
    input  logic              load_valid,
    input  logic              fault_report,
    input  logic              repair_lock,
    output logic              unrepairable
);

    localparam int SPARE_BASE = 1 << ROW_W;

    logic [NUM_SPARES-1:0]            tbl_valid;
    logic [NUM_SPARES-1:0][ROW_W-1:0] tbl_addr;
    logic                             sealed;
    logic                             hit;
    logic [IDX_W-1:0]                 hit_idx;

    remap_table #(
        .ROW_W(ROW_W), .NUM_SPARES(NUM_SPARES), .IDX_W(IDX_W)
    ) table_i (
        .clk(clk), .rst(rst),
        .load_en(load_en), .load_idx(load_idx), .load_addr(load_addr),
        .load_valid(load_valid), .repair_lock(repair_lock),
        .tbl_valid(tbl_valid), .tbl_addr(tbl_addr), .sealed(sealed)
    );

    remap_match #(
        .ROW_W(ROW_W), .NUM_SPARES(NUM_SPARES), .IDX_W(IDX_W)
    ) match_i (
        .log_row(log_row), .tbl_valid(tbl_valid), .tbl_addr(tbl_addr),
        .hit(hit), .hit_idx(hit_idx)
    );

    fault_tally #(
        .NUM_SPARES(NUM_SPARES)
    ) tally_i (
        .clk(clk), .rst(rst), .fault_report(fault_report),
        .repair_lock(repair_lock), .sealed(sealed),
        .unrepairable(unrepairable)
    );

    assign remap_hit = hit;
    assign phys_row  = hit ? (PHYS_W'(SPARE_BASE) + PHYS_W'(hit_idx))
                           : PHYS_W'(log_row);

    // R2: misses go through untouched
    assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        !remap_hit |-> (phys_row == PHYS_W'(log_row)));

    // R1: hits land only inside the spare window
    assert_spare_window_R1: assert property (@(posedge clk) disable iff (rst)
        remap_hit |-> ((phys_row >= PHYS_W'(SPARE_BASE)) &&
                       (phys_row <  PHYS_W'(SPARE_BASE + NUM_SPARES))));

endmodule

// File: tb/spare_row_remap_tb_top.sv
module spare_row_remap_tb_top;

    localparam int ROW_W  = 6;
    localparam int PHYS_W = 7;
    localparam int IDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ROW_W-1:0]  log_row = '0;
    logic [PHYS_W-1:0] phys_row;
    logic              remap_hit;
    logic              load_en = 1'b0;
    logic [IDX_W-1:0]  load_idx = '0;
    logic [ROW_W-1:0]  load_addr = '0;
    logic              load_valid = 1'b0;
    logic              fault_report = 1'b0;
    logic              repair_lock = 1'b0;
    logic              unrepairable;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic exp_unrep = 1'b0;

    typedef struct {
        logic [PHYS_W-1:0] phys;
        logic              hit;
        logic              unrep;
        string             req;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    spare_row_remap dut_i (
        .clk(clk), .rst(rst), .log_row(log_row), .phys_row(phys_row),
        .remap_hit(remap_hit), .load_en(load_en), .load_idx(load_idx),
        .load_addr(load_addr), .load_valid(load_valid),
        .fault_report(fault_report), .repair_lock(repair_lock),
        .unrepairable(unrepairable)
    );

    // driver: apply an address, queue the expected response
    task automatic expect_row(input logic [ROW_W-1:0] row,
                              input logic [PHYS_W-1:0] ep,
                              input logic eh, input string req);
        exp_t it;
        @(negedge clk); #1;
        log_row  = row;
        it.phys  = ep;
        it.hit   = eh;
        it.unrep = exp_unrep;
        it.req   = req;
        sb_q.push_back(it);
    endtask

    task automatic load(input int idx, input int addr, input logic v);
        @(negedge clk); #1;
        load_en = 1'b1; load_idx = IDX_W'(idx);
        load_addr = ROW_W'(addr); load_valid = v;
        @(negedge clk); #1;
        load_en = 1'b0; load_valid = 1'b0;
    endtask

    task automatic report_fault();
        @(negedge clk); #1; fault_report = 1'b1;
        @(negedge clk); #1; fault_report = 1'b0;
    endtask

    task automatic pulse_lock();
        @(negedge clk); #1; repair_lock = 1'b1;
        @(negedge clk); #1; repair_lock = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); #1; rst = 1'b1;
        repeat (2) @(negedge clk);
        #1; rst = 1'b0;
        exp_unrep = 1'b0;
    endtask

    // monitor: sample away from the clock edge and compare
    initial begin
        forever begin
            @(negedge clk); #3;
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (phys_row !== it.phys) begin
                    errors++;
                    $display("FAIL %s phys_row actual=%0d expected=%0d", it.req, phys_row, it.phys);
                end
                checks++;
                if (remap_hit !== it.hit) begin
                    errors++;
                    $display("FAIL %s remap_hit actual=%0b expected=%0b", it.req, remap_hit, it.hit);
                end
                checks++;
                if (unrepairable !== it.unrep) begin
                    errors++;
                    $display("FAIL %s unrepairable actual=%0b expected=%0b", it.req, unrepairable, it.unrep);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1; rst = 1'b0;

        // R9: reset state passes everything through
        expect_row(6'd5,  7'd5,  1'b0, "R9");
        expect_row(6'd63, 7'd63, 1'b0, "R2");

        // R3/R6: first entry, visible after the load edge
        load(0, 10, 1'b1);
        expect_row(6'd10, 7'd64, 1'b1, "R3");
        expect_row(6'd11, 7'd11, 1'b0, "R2");

        // R1: entry 2 maps to row 66
        load(2, 20, 1'b1);
        expect_row(6'd20, 7'd66, 1'b1, "R1");

        // R5: duplicate in entry 3, entry 0 keeps priority
        load(3, 10, 1'b1);
        expect_row(6'd10, 7'd64, 1'b1, "R5");

        // R4: invalidated entry 0 no longer matches, entry 3 takes over
        load(0, 10, 1'b0);
        expect_row(6'd10, 7'd67, 1'b1, "R4");

        // R5: duplicate in entry 1 beats entry 2
        load(1, 20, 1'b1);
        expect_row(6'd20, 7'd65, 1'b1, "R5");

        // R10: rewrite entry 1 to a new row
        load(1, 40, 1'b1);
        expect_row(6'd20, 7'd66, 1'b1, "R10");
        expect_row(6'd40, 7'd65, 1'b1, "R10");

        // R8: exactly NUM_SPARES reports keep the part repairable
        for (int i = 0; i < 4; i++) report_fault();
        expect_row(6'd1, 7'd1, 1'b0, "R8");

        // R6: a load under an active lock is ignored
        @(negedge clk); #1;
        repair_lock = 1'b1; load_en = 1'b1; load_idx = 2'd0;
        load_addr = 6'd50; load_valid = 1'b1;
        @(negedge clk); #1;
        repair_lock = 1'b0; load_en = 1'b0; load_valid = 1'b0;
        expect_row(6'd50, 7'd50, 1'b0, "R6");

        // R7: lock dropped, table stays sealed
        load(0, 50, 1'b1);
        expect_row(6'd50, 7'd50, 1'b0, "R7");
        expect_row(6'd40, 7'd65, 1'b1, "R7");
        report_fault();
        expect_row(6'd2, 7'd2, 1'b0, "R7");

        // R9: reset clears table and count
        do_reset();
        expect_row(6'd40, 7'd40, 1'b0, "R9");
        expect_row(6'd10, 7'd10, 1'b0, "R9");

        // R8: one report beyond the spare count flags the part, sticky
        for (int i = 0; i < 5; i++) report_fault();
        exp_unrep = 1'b1;
        expect_row(6'd3, 7'd3, 1'b0, "R8");
        pulse_lock();
        expect_row(6'd4, 7'd4, 1'b0, "R8");

        // R6: load accepted again after reset
        do_reset();
        pulse_lock();
        do_reset();
        load(3, 7, 1'b1);
        expect_row(6'd7, 7'd67, 1'b1, "R6");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule